// File: doc/BRIEF.md
# Multicore CPU release configuration block

This block is a word-addressed register window of 1 KiB that sets up and releases the cores of a four-core processor cluster. Software keeps three writable words in it: a general control word, a standby flag and the address at which a released core begins execution. The remaining registers in the window hold constants. They tell software that the cluster is out of reset, that each core runs in coherent mode and that all core clocks are enabled.

Writing a nonzero value to a core's reset-control word releases that core. On the next clock edge the block raises that core's bit of a one-hot start vector for exactly one cycle. During that cycle the stored entry address, a context argument of zero and a fixed privilege level of 3 are driven beside the pulse. Writing zero to the same word does nothing.

Reads are combinational from the address. Writes, start pulses and the access-error flag are registered. An access to a reserved, unmapped or misaligned offset returns zero, changes nothing and raises the error flag for one cycle.

Top module: `cpu_launch_cfg`

## Requirements
- R1: While reset is applied and after it is released, general control holds 0x20, the standby flag holds 0 and the entry address holds 0. The start vector is 0 and the error flag is 0.
- R2: General control (0x184), standby flag (0x1A0) and entry address (0x1A4) store all 32 bits of a write. The new value reads back from the cycle after the write strobe.
- R3: Offsets 0x000 and 0x140 read 0x1 and offset 0x144 reads 0x10F. For core i (0..3), with base 0x40·(i+1), base+0 reads 0x3, base+4 reads 0x0 and base+8 reads 0x1.
- R4: Writes to the constant registers listed in R3 leave every readable value unchanged. Writes to base+4 and base+8 of any core raise no start pulse.
- R5: A write of a nonzero value to offset 0x40·(i+1) sets bit i of `core_start` in the next cycle only. At most one bit of `core_start` is ever set.
- R6: A write of zero to a core's reset-control offset raises no start pulse.
- R7: In the cycle that `core_start` is nonzero, `start_pc` equals the entry address register, `start_level` is 3 and `start_arg` is 0.
- R8: Offsets 0x1E4, 0x280, 0x284, 0x288, every other unlisted offset and every offset with address bits [1:0] nonzero read 0 and ignore writes. A read or write strobe to such an offset sets `bad_access` in the next cycle. Accesses to the offsets in R2 and R3 never set it.
- R9: `bus_rdata` follows `bus_addr` in the same cycle, whether or not `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, used only for error reporting |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| core_start | output | 4 | One-hot, single-cycle core release request |
| start_pc | output | 32 | Entry address delivered with the request |
| start_arg | output | 32 | Context argument delivered with the request (zero) |
| start_level | output | 2 | Privilege level delivered with the request (3) |
| bad_access | output | 1 | One-cycle flag for an access to a reserved or unmapped offset |

## Verification
Read data is due in the same cycle as the address. The bench checks it one time step after it drives the address on a falling edge. Stored words, the start vector and the error flag are all due one rising edge after the strobe. The bench drives each strobe on a falling edge and checks those outputs on the next falling edge. It also checks one falling edge later that the start pulse is gone. Sweeps cover every word offset for reads and writes, with expected values computed from the offset arithmetic.

// File: rtl/cpu_launch_cfg.sv
module cpu_launch_cfg #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int CORES     = 4,
  parameter int LEVEL_W   = 2,
  parameter int RUN_LEVEL = 3,
  parameter logic [31:0] GEN_RESET = 32'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [CORES-1:0]   core_start,
  output logic [DATA_W-1:0]  start_pc,
  output logic [DATA_W-1:0]  start_arg,
  output logic [LEVEL_W-1:0] start_level,
  output logic               bad_access
);

  localparam int OFS_CLUSTER = 'h000;
  localparam int OFS_CORE0   = 'h040;
  localparam int CORE_STRIDE = 'h040;
  localparam int OFS_SYSRST  = 'h140;
  localparam int OFS_CLKGATE = 'h144;
  localparam int OFS_GEN     = 'h184;
  localparam int OFS_STANDBY = 'h1A0;
  localparam int OFS_ENTRY   = 'h1A4;

  logic              word_ok;
  logic [CORES-1:0]  hit_rst, hit_ctl, hit_sts;
  logic              hit_clu, hit_sys, hit_clk, hit_gen, hit_stb, hit_ent, known;
  logic [DATA_W-1:0] gen_q, stb_q, entry_q;

  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign hit_clu = word_ok && (bus_addr == ADDR_W'(OFS_CLUSTER));
  assign hit_sys = word_ok && (bus_addr == ADDR_W'(OFS_SYSRST));
  assign hit_clk = word_ok && (bus_addr == ADDR_W'(OFS_CLKGATE));
  assign hit_gen = word_ok && (bus_addr == ADDR_W'(OFS_GEN));
  assign hit_stb = word_ok && (bus_addr == ADDR_W'(OFS_STANDBY));
  assign hit_ent = word_ok && (bus_addr == ADDR_W'(OFS_ENTRY));

  for (genvar g = 0; g < CORES; g++) begin : g_core
    localparam int BASE = OFS_CORE0 + g * CORE_STRIDE;
    assign hit_rst[g] = word_ok && (bus_addr == ADDR_W'(BASE));
    assign hit_ctl[g] = word_ok && (bus_addr == ADDR_W'(BASE + 4));
    assign hit_sts[g] = word_ok && (bus_addr == ADDR_W'(BASE + 8));
  end

  assign known = hit_clu | hit_sys | hit_clk | hit_gen | hit_stb | hit_ent
               | (|hit_rst) | (|hit_ctl) | (|hit_sts);

  always_comb begin
    bus_rdata = '0;
    if (hit_clu || hit_sys) bus_rdata = DATA_W'(32'h1);
    if (|hit_rst)           bus_rdata = DATA_W'(32'h3);
    if (|hit_sts)           bus_rdata = DATA_W'(32'h1);
    if (hit_clk)            bus_rdata = DATA_W'(32'h10F);
    if (hit_gen)            bus_rdata = gen_q;
    if (hit_stb)            bus_rdata = stb_q;
    if (hit_ent)            bus_rdata = entry_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q      <= DATA_W'(GEN_RESET);
      stb_q      <= '0;
      entry_q    <= '0;
      core_start <= '0;
      bad_access <= 1'b0;
    end else begin
      if (bus_wr && hit_gen) gen_q   <= bus_wdata;
      if (bus_wr && hit_stb) stb_q   <= bus_wdata;
      if (bus_wr && hit_ent) entry_q <= bus_wdata;
      core_start <= (bus_wr && (bus_wdata != '0)) ? hit_rst : '0;
      bad_access <= (bus_wr || bus_rd) && !known;
    end
  end

  assign start_pc    = entry_q;
  assign start_arg   = '0;
  assign start_level = LEVEL_W'(RUN_LEVEL);

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_start)); // R5
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start != '0) |-> ($past(bus_wr) && $past(bus_wdata) != '0)); // R6
  AST_START_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start != '0) |-> (start_pc == $past(entry_q))); // R7
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr) |-> ($stable(gen_q) && $stable(stb_q) && $stable(entry_q))); // R4
  AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && hit_ent) |-> (entry_q == $past(bus_wdata))); // R2
  AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(bus_wr || bus_rd)); // R8

endmodule

// File: tb/cpu_launch_cfg_test.sv
module cpu_launch_cfg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, start_pc, start_arg;
  logic [3:0]  core_start;
  logic [1:0]  start_level;
  logic        bad_access;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] m_gen = 32'h20, m_stb = 32'h0, m_ent = 32'h0;

  cpu_launch_cfg uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic bit is_known(int o);
    if (o % 4 != 0) return 0;
    if (o == 'h000 || o == 'h140 || o == 'h144 || o == 'h184 || o == 'h1A0 || o == 'h1A4) return 1;
    if (o >= 'h40 && o < 'h140 && (o % 64) <= 8) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(int o);
    if (!is_known(o)) return 32'h0;
    case (o)
      'h000, 'h140: return 32'h1;
      'h144: return 32'h10F;
      'h184: return m_gen;
      'h1A0: return m_stb;
      'h1A4: return m_ent;
      default: case (o % 64) 0: return 32'h3; 4: return 32'h0; default: return 32'h1; endcase
    endcase
  endfunction

  function automatic logic [3:0] exp_start(int o, logic [31:0] d);
    if (d == 0 || o % 64 != 0 || o < 'h40 || o >= 'h140) return 4'h0;
    return 4'h1 << ((o - 'h40) >> 6);
  endfunction

  task automatic do_read(input int o, input bit strobe, input string req);
    @(negedge clk);
    bus_addr = 10'(o); bus_rd = strobe;
    #1 chk(bus_rdata == exp_read(o), req, bus_rdata, exp_read(o));
    @(negedge clk);
    bus_rd = 1'b0;
    if (strobe) chk(bad_access == !is_known(o), "R8", 32'(bad_access), 32'(!is_known(o)));
  endtask

  task automatic do_write(input int o, input logic [31:0] d);
    logic [3:0] es;
    es = exp_start(o, d);
    @(negedge clk);
    bus_addr = 10'(o); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (is_known(o) && o == 'h184) m_gen = d;
    if (is_known(o) && o == 'h1A0) m_stb = d;
    if (is_known(o) && o == 'h1A4) m_ent = d;
    chk(core_start == es, (d == 0) ? "R6" : "R5", 32'(core_start), 32'(es));
    chk(bad_access == !is_known(o), "R8", 32'(bad_access), 32'(!is_known(o)));
    if (es != 0) begin
      chk(start_pc == m_ent, "R7", start_pc, m_ent);
      chk(start_level == 2'd3 && start_arg == 0, "R7", {start_arg[29:0], start_level}, 32'h3);
    end
    @(negedge clk);
    chk(core_start == 4'h0, "R5", 32'(core_start), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(core_start == 0 && bad_access == 0 && start_pc == 0, "R1",
        {27'h0, bad_access, core_start}, 32'h0);
    rst_n = 1'b1;
    do_read('h184, 1, "R1");
    do_read('h1A0, 1, "R1");
    do_read('h1A4, 1, "R1");
    for (int o = 0; o < 1024; o += 4) do_read(o, 1, "R3");
    for (int o = 1; o < 16; o += 5) do_read('h180 + o, 1, "R8");
    for (int o = 0; o < 1024; o += 16) do_read(o, 0, "R9");
    do_write('h1A4, 32'h8000_1234);
    do_read('h1A4, 1, "R2");
    for (int i = 0; i < 4; i++) do_write('h40 + 64 * i, 32'h0);
    for (int i = 0; i < 4; i++) do_write('h40 + 64 * i, 32'h1 << i);
    do_write('h184, 32'hFFFF_FFFF); do_read('h184, 1, "R2");
    do_write('h1A0, 32'hDEAD_BEEF); do_read('h1A0, 1, "R2");
    for (int o = 0; o < 1024; o += 4) do_write(o, {6'h0, 10'(o), 16'hA5C3});
    for (int o = 0; o < 1024; o += 4) do_read(o, 1, "R4");
    finish_run();
  end
endmodule